// File: doc/BRIEF.md
# Dual-Issue Warp Issue Stage

This block is the issue stage of one multiprocessor in a SIMT core. It holds two warp schedulers that work side by side. Warps with an even ID belong to the first scheduler and warps with an odd ID belong to the second. In every cycle each scheduler looks over its own warps and picks one warp whose next instruction can go. The pick follows a rotating priority, so the warps of one scheduler take turns over time. Each grant covers one instruction for a whole 32-thread warp.

Both schedulers normally issue in the same cycle, to different execution-unit groups. The stage also enforces the pairing rules. A double-precision instruction uses both core groups, so it never shares its cycle with another grant. Only one load/store group and one special-function group exist, so two grants cannot both target one of them. When such a conflict occurs, the even side wins and the odd side waits. A unit group that reports busy blocks every instruction that targets it.

The stage takes per-warp valid, ready and class signals and one busy bit per unit group. It drives two registered grant ports, each carrying a valid bit, a warp ID and a unit code.

Top module: `dual_warp_issue`

## Requirements
- R1: While `rst_n` is low at a clock edge, both grant ports are cleared on that edge. After reset is released, each scheduler starts its search at its slot 0, which is warp 0 on the even side and warp 1 on the odd side.
- R2: Each scheduler picks the first eligible slot at or after its rotating pointer, wrapping from the last slot back to slot 0. When it issues, its pointer moves to one past the issued slot.
- R3: A double-precision grant is never paired with a second grant in the same cycle. When the even side issues a double-precision instruction, the odd side issues nothing in that cycle.
- R4: Port 0 carries only even-side grants and port 1 carries only odd-side grants. The warp ID is 2*slot for the even side and 2*slot+1 for the odd side.
- R5: If both sides pick load/store instructions, or both pick special-function instructions, only the even side issues. The odd side's pointer stays where it was, so the same odd warp is chosen again in the next cycle.
- R6: An instruction is not eligible while its target group is busy. The busy bits are: bit 0 for core group 0 (even-side arithmetic), bit 1 for core group 1 (odd-side arithmetic), bit 2 for load/store and bit 3 for special-function. A double-precision instruction needs both bit 0 and bit 1 to be clear.
- R7: An odd-side double-precision instruction issues only in a cycle in which the even side has no eligible warp. Otherwise it waits, and the odd pointer does not move.
- R8: Grants are registered. The inputs present at a clock edge decide the grant outputs that follow that edge. Each grant is held for exactly one cycle, and it drops if the next decision does not issue.
- R9: The class codes are 0 arithmetic, 1 load/store, 2 special-function and 3 double-precision. The unit codes are 0 core group 0, 1 core group 1, 2 load/store, 3 special-function and 4 double-precision (both core groups). Arithmetic goes to core group 0 on the even side and to core group 1 on the odd side.
- R10: A warp is eligible only when both its valid bit and its ready bit are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| warp_vld | input | 48 | Per-warp valid bit: the warp is resident and has an instruction |
| warp_rdy | input | 48 | Per-warp ready bit: the operands are clear |
| warp_cls | input | 96 | Per-warp 2-bit class code; warp w uses bits [2w+1:2w] |
| unit_busy | input | 4 | Busy bits: core group 0, core group 1, load/store, special-function |
| gnt0_vld | output | 1 | Even-side grant valid |
| gnt0_warp | output | 6 | Even-side granted warp ID |
| gnt0_unit | output | 3 | Even-side target unit code |
| gnt1_vld | output | 1 | Odd-side grant valid |
| gnt1_warp | output | 6 | Odd-side granted warp ID |
| gnt1_unit | output | 3 | Odd-side target unit code |

## Verification
The stage is tried with several input patterns. Full occupancy with only arithmetic instructions shows the pointer start after reset and the parity split between the ports. A stream of even arithmetic warps walks the rotating pointer. Valid-but-not-ready warps test the eligibility rule. Double-precision on either side shows the difference between the even side blocking its partner and the odd side having to wait. Matching load/store picks show that the odd pointer holds its place when the odd side loses. Single busy bits show that only the targeted group is blocked. A long random phase mixes all four classes and busy bits against a behavioural model, cycle by cycle, which finds ordering errors that the directed cases miss.

// File: rtl/dwi_pkg.sv
// Package: class and unit encodings shared by the issue stage.
// Assumes 2-bit class codes and 3-bit unit codes as listed in the brief.
package dwi_pkg;
    localparam logic [1:0] C_ALU = 2'd0;
    localparam logic [1:0] C_LSU = 2'd1;
    localparam logic [1:0] C_SFU = 2'd2;
    localparam logic [1:0] C_DP  = 2'd3;

    localparam logic [2:0] U_CG0 = 3'd0;
    localparam logic [2:0] U_CG1 = 3'd1;
    localparam logic [2:0] U_LSU = 3'd2;
    localparam logic [2:0] U_SFU = 3'd3;
    localparam logic [2:0] U_DP  = 3'd4;

    localparam int BZ_CG0 = 0;
    localparam int BZ_CG1 = 1;
    localparam int BZ_LSU = 2;
    localparam int BZ_SFU = 3;
    localparam int BZ_W   = 4;
endpackage

// File: rtl/dwi_rr_pick.sv
// Module: rotating-priority picker. It returns the first set request at or
// after ptr, wrapping at N. Purely combinational.
// Assumes ptr < N.
module dwi_rr_pick #(
    parameter int N  = 24,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic          any,
    output logic [IW-1:0] idx
);
    logic [IW:0] cand;

    // Scan from ptr upward and keep the first request found.
    always_comb begin
        any  = 1'b0;
        idx  = '0;
        cand = '0;
        for (int k = 0; k < N; k++) begin
            cand = {1'b0, ptr} + (IW+1)'(k);
            if (cand >= (IW+1)'(N)) cand = cand - (IW+1)'(N);
            if (!any && req[cand[IW-1:0]]) begin
                any = 1'b1;
                idx = cand[IW-1:0];
            end
        end
    end
endmodule

// File: rtl/dwi_side.sv
// Module: one warp scheduler. It owns NS warp slots. It works out which
// slots are eligible (valid, ready, target unit free), picks one with a
// rotating pointer, and moves the pointer only when told its pick issued.
// Assumes the caller has already split the warps by parity; SIDE selects
// the core group that arithmetic uses.
module dwi_side
    import dwi_pkg::*;
#(
    parameter int NS   = 24,
    parameter int SIDE = 0,
    parameter int SW   = (NS > 1) ? $clog2(NS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NS-1:0]   vld,
    input  logic [NS-1:0]   rdy,
    input  logic [2*NS-1:0] cls,
    input  logic [BZ_W-1:0] busy,
    input  logic            advance,
    output logic            has_pick,
    output logic [SW-1:0]   pick_slot,
    output logic [1:0]      pick_cls,
    output logic [2:0]      pick_unit
);
    localparam logic [2:0] U_ARITH = (SIDE == 0) ? U_CG0 : U_CG1;

    logic [NS-1:0] elig;
    logic [SW-1:0] ptr;

    // Map a class code to this side's target unit.
    function automatic logic [2:0] unit_of(input logic [1:0] c);
        case (c)
            C_ALU:   unit_of = U_ARITH;
            C_LSU:   unit_of = U_LSU;
            C_SFU:   unit_of = U_SFU;
            default: unit_of = U_DP;
        endcase
    endfunction

    // True when the unit group(s) behind a unit code are free.
    function automatic logic unit_free(input logic [2:0] u, input logic [BZ_W-1:0] b);
        case (u)
            U_CG0:   unit_free = !b[BZ_CG0];
            U_CG1:   unit_free = !b[BZ_CG1];
            U_LSU:   unit_free = !b[BZ_LSU];
            U_SFU:   unit_free = !b[BZ_SFU];
            default: unit_free = !b[BZ_CG0] && !b[BZ_CG1];
        endcase
    endfunction

    for (genvar i = 0; i < NS; i++) begin : g_elig
        // Per-slot eligibility: valid, ready and target unit free.
        always_comb elig[i] = vld[i] && rdy[i] && unit_free(unit_of(cls[2*i +: 2]), busy);
    end

    dwi_rr_pick #(.N(NS), .IW(SW)) u_pick (
        .req (elig),
        .ptr (ptr),
        .any (has_pick),
        .idx (pick_slot)
    );

    // Class and unit of the chosen slot.
    always_comb begin
        pick_cls  = cls[2*pick_slot +: 2];
        pick_unit = unit_of(pick_cls);
    end

    // Pointer moves to one past the issued slot; it holds on a stall.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (advance)
            ptr <= (pick_slot == SW'(NS-1)) ? '0 : pick_slot + SW'(1);
    end

    p_adv_needs_pick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> has_pick);
    p_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(ptr));
endmodule

// File: rtl/dual_warp_issue.sv
// Module: dual-issue warp issue stage. It splits the warps by ID parity
// over two schedulers, applies the pairing rules (double-precision issues
// alone, the even side wins a shared unit) and registers both grants.
// Assumes NUM_WARPS is even; unit_busy follows the dwi_pkg bit order.
module dual_warp_issue
    import dwi_pkg::*;
#(
    parameter int NUM_WARPS = 48,
    localparam int NS    = NUM_WARPS / 2,
    localparam int WID_W = $clog2(NUM_WARPS),
    localparam int SW    = (NS > 1) ? $clog2(NS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_WARPS-1:0]   warp_vld,
    input  logic [NUM_WARPS-1:0]   warp_rdy,
    input  logic [2*NUM_WARPS-1:0] warp_cls,
    input  logic [BZ_W-1:0]        unit_busy,
    output logic                   gnt0_vld,
    output logic [WID_W-1:0]       gnt0_warp,
    output logic [2:0]             gnt0_unit,
    output logic                   gnt1_vld,
    output logic [WID_W-1:0]       gnt1_warp,
    output logic [2:0]             gnt1_unit
);
    logic [NS-1:0]   ev_vld, ev_rdy, od_vld, od_rdy;
    logic [2*NS-1:0] ev_cls, od_cls;
    logic            e_has, o_has, e_go, o_go;
    logic [SW-1:0]   e_slot, o_slot;
    logic [1:0]      e_cls, o_cls;
    logic [2:0]      e_unit, o_unit;

    for (genvar i = 0; i < NS; i++) begin : g_split
        // Route warp 2i to the even side and warp 2i+1 to the odd side.
        always_comb begin
            ev_vld[i]        = warp_vld[2*i];
            ev_rdy[i]        = warp_rdy[2*i];
            ev_cls[2*i +: 2] = warp_cls[4*i +: 2];
            od_vld[i]        = warp_vld[2*i+1];
            od_rdy[i]        = warp_rdy[2*i+1];
            od_cls[2*i +: 2] = warp_cls[4*i+2 +: 2];
        end
    end

    dwi_side #(.NS(NS), .SIDE(0), .SW(SW)) u_even (
        .clk(clk), .rst_n(rst_n), .vld(ev_vld), .rdy(ev_rdy), .cls(ev_cls),
        .busy(unit_busy), .advance(e_go), .has_pick(e_has),
        .pick_slot(e_slot), .pick_cls(e_cls), .pick_unit(e_unit)
    );

    dwi_side #(.NS(NS), .SIDE(1), .SW(SW)) u_odd (
        .clk(clk), .rst_n(rst_n), .vld(od_vld), .rdy(od_rdy), .cls(od_cls),
        .busy(unit_busy), .advance(o_go), .has_pick(o_has),
        .pick_slot(o_slot), .pick_cls(o_cls), .pick_unit(o_unit)
    );

    // Pairing rules: even always goes; odd yields to any DP or a shared unit.
    always_comb begin
        e_go = e_has;
        o_go = o_has && !(e_has && (e_cls == C_DP || o_cls == C_DP || e_unit == o_unit));
    end

    // Register both grant ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt0_vld  <= 1'b0;
            gnt0_warp <= '0;
            gnt0_unit <= '0;
            gnt1_vld  <= 1'b0;
            gnt1_warp <= '0;
            gnt1_unit <= '0;
        end else begin
            gnt0_vld  <= e_go;
            gnt0_warp <= e_go ? WID_W'({e_slot, 1'b0}) : '0;
            gnt0_unit <= e_go ? e_unit : '0;
            gnt1_vld  <= o_go;
            gnt1_warp <= o_go ? WID_W'({o_slot, 1'b1}) : '0;
            gnt1_unit <= o_go ? o_unit : '0;
        end
    end

    p_dp_unpaired_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt0_vld && gnt1_vld) |-> (gnt0_unit != U_DP && gnt1_unit != U_DP));
    p_port_parity0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        gnt0_vld |-> !gnt0_warp[0]);
    p_port_parity1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        gnt1_vld |-> gnt1_warp[0]);
    p_no_shared_unit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt0_vld && gnt1_vld) |-> (gnt0_unit != gnt1_unit));
    p_lsu_busy0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt0_vld && gnt0_unit == U_LSU) |-> !$past(unit_busy[BZ_LSU]));
    p_lsu_busy1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt1_vld && gnt1_unit == U_LSU) |-> !$past(unit_busy[BZ_LSU]));
    p_sfu_busy0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt0_vld && gnt0_unit == U_SFU) |-> !$past(unit_busy[BZ_SFU]));
    p_sfu_busy1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt1_vld && gnt1_unit == U_SFU) |-> !$past(unit_busy[BZ_SFU]));
    p_odd_dp_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt1_vld && gnt1_unit == U_DP) |-> !gnt0_vld);
endmodule

// File: tb/dual_warp_issue_tb.sv
module dual_warp_issue_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 48;
    localparam int NS = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NW-1:0] v = '0, r = '0;
    logic [2*NW-1:0] c = '0;
    logic [3:0]    busy = '0;
    logic          g0v, g1v;
    logic [5:0]    g0w, g1w;
    logic [2:0]    g0u, g1u;

    int n_run = 0, n_fail = 0;
    int pe = 0, po = 0;
    bit xev, xov;
    int xew, xeu, xow, xou;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_warp_issue dut_i (
        .clk(clk), .rst_n(rst_n), .warp_vld(v), .warp_rdy(r), .warp_cls(c),
        .unit_busy(busy), .gnt0_vld(g0v), .gnt0_warp(g0w), .gnt0_unit(g0u),
        .gnt1_vld(g1v), .gnt1_warp(g1w), .gnt1_unit(g1u)
    );

    function automatic int cls_of(int w);
        return int'(c[2*w +: 2]);
    endfunction

    function automatic int unit_of(int cl, int side);
        case (cl)
            0: return side;
            1: return 2;
            2: return 3;
            default: return 4;
        endcase
    endfunction

    function automatic bit free_u(int u);
        case (u)
            0: return !busy[0];
            1: return !busy[1];
            2: return !busy[2];
            3: return !busy[3];
            default: return !busy[0] && !busy[1];
        endcase
    endfunction

    function automatic int first_pick(int ptr, int side);
        for (int k = 0; k < NS; k++) begin
            int s = (ptr + k) % NS;
            int w = 2*s + side;
            if (v[w] && r[w] && free_u(unit_of(cls_of(w), side))) return s;
        end
        return -1;
    endfunction

    // Behavioural model of one decision from the current inputs.
    task automatic model();
        int es = first_pick(pe, 0);
        int os = first_pick(po, 1);
        int ecl = (es >= 0) ? cls_of(2*es) : -1;
        int ocl = (os >= 0) ? cls_of(2*os+1) : -1;
        xev = (es >= 0);
        xov = (os >= 0);
        xeu = xev ? unit_of(ecl, 0) : 0;
        xou = xov ? unit_of(ocl, 1) : 0;
        if (xev && xov && (ecl == 3 || ocl == 3 || xeu == xou)) xov = 0;
        xew = xev ? 2*es : 0;
        xow = xov ? 2*os+1 : 0;
        if (!xov) xou = 0;
        if (xev) pe = (es + 1) % NS;
        if (xov) po = (os + 1) % NS;
    endtask

    task automatic compare(string tag);
        n_run++;
        if (g0v !== xev || (xev && (int'(g0w) != xew || int'(g0u) != xeu))) begin
            n_fail++;
            $display("FAIL %s port0: got v=%0b w=%0d u=%0d exp v=%0b w=%0d u=%0d",
                     tag, g0v, g0w, g0u, xev, xew, xeu);
        end
        n_run++;
        if (g1v !== xov || (xov && (int'(g1w) != xow || int'(g1u) != xou))) begin
            n_fail++;
            $display("FAIL %s port1: got v=%0b w=%0d u=%0d exp v=%0b w=%0d u=%0d",
                     tag, g1v, g1w, g1u, xov, xow, xou);
        end
    endtask

    // Apply the inputs set by the caller for one edge, then check the grants.
    task automatic cycle(string tag);
        model();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic clr();
        v = '0; r = '0; c = '0; busy = '0;
    endtask

    task automatic setw(int w, int cl);
        v[w] = 1'b1; r[w] = 1'b1; c[2*w +: 2] = 2'(cl);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: outputs cleared while in reset even with all warps eligible
        v = '1; r = '1; c = '0;
        repeat (3) @(negedge clk);
        n_run++;
        if (g0v !== 1'b0 || g1v !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: got v0=%0b v1=%0b exp 0 0", g0v, g1v);
        end
        rst_n = 1'b1;
        // R1 R4 R9: first pick after reset is slot 0 on each side
        cycle("R1 R4 R9 start");
        // R8: grant drops when nothing issues
        clr();
        cycle("R8 one-cycle grant");
        // R2: even arithmetic stream walks the pointer
        clr();
        for (int i = 0; i < 6; i++) setw(2*i, 0);
        repeat (4) cycle("R2 rotation");
        // R10: valid without ready, ready without valid
        clr();
        v[4] = 1'b1; r[5] = 1'b1;
        cycle("R10 valid and ready");
        // R3: even DP blocks odd arithmetic
        clr();
        setw(10, 3); setw(11, 0);
        cycle("R3 even DP");
        // R7: odd DP alone, then odd DP waits for even arithmetic
        clr();
        setw(13, 3);
        cycle("R7 odd DP alone");
        clr();
        setw(13, 3); setw(12, 0);
        cycle("R7 odd DP waits");
        // R5: shared load/store, odd loses and keeps its warp
        clr();
        setw(20, 1); setw(21, 1); setw(23, 1);
        cycle("R5 LSU clash");
        clr();
        setw(21, 1); setw(23, 1);
        cycle("R5 odd pointer held");
        clr();
        setw(30, 2); setw(31, 2);
        cycle("R5 SFU clash");
        // R6: busy groups block only their own targets
        clr();
        busy = 4'b0100; setw(2, 1); setw(3, 0);
        cycle("R6 LSU busy");
        clr();
        busy = 4'b0001; setw(4, 0); setw(5, 0);
        cycle("R6 core group 0 busy");
        clr();
        busy = 4'b0010; setw(6, 3); setw(7, 2);
        cycle("R6 DP needs both groups");
        // Mixed random traffic
        for (int n = 0; n < 400; n++) begin
            clr();
            for (int w = 0; w < NW; w++) begin
                v[w] = ($urandom_range(0, 3) != 0);
                r[w] = ($urandom_range(0, 2) != 0);
                c[2*w +: 2] = 2'($urandom_range(0, 3));
            end
            busy = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'b0;
            cycle("R2 R3 R5 R6 R7 random");
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule